// File: doc/BRIEF.md
# CAN Fault Confinement Interrupt Unit

This block follows the fault-confinement state of one CAN node and raises sticky interrupt flags when that state changes. The protocol engine supplies three things: the transmit and receive error counts, a sample of the bus level on each bit-time strobe, and a pulse when it detects an overload condition. The block turns these inputs into a node state (error-active, error-passive, bus-off or halted). It sets a flag on each of these events: an overload, a bus-off event and entry into error-passive. It also drives an enable that tells the engine to send an overload frame.

While the node is bus-off, the block counts runs of eleven recessive bits. After the configured number of runs, the node returns to error-active. A halt request received during bus-off moves the node into a halted state. Software clears each flag by writing a 1 to its bit. A flag stays set whatever the node state does in the meantime.

Top module: `can_fault_irq`

## Requirements
- R1: After a synchronous reset, node_state is 2'b00 (error-active), flags is 3'b000, ovl_tx_en is 0 and the recovery run count is zero.
- R2: node_state encodes 2'b00 error-active, 2'b01 error-passive, 2'b10 bus-off and 2'b11 halted. From error-active or error-passive, tec >= 256 moves the node to bus-off on the next clock and sets flags[1] (the bus-off flag).
- R3: From error-active, tec >= 128, rec >= 128 or force_passive high (with tec < 256) moves the node to error-passive on the next clock. That transition sets flags[2] once; the flag is not set again while the condition persists.
- R4: From error-passive, the node returns to error-active when tec < 128, rec < 128 and force_passive is low. This transition sets no flag.
- R5: In bus-off, each bit_stb with bus_rx = 1 (recessive) extends the current run. The 11th such bit completes a run. The completion of the 128th run returns the node to error-active and sets flags[1]. A dominant bit (bus_rx = 0) on a strobe restarts only the current run. Cycles without bit_stb are ignored.
- R6: In bus-off, halt_req high moves the node to halted on the next clock and sets flags[1]. halt_req has priority over a completing recovery. In halted, halt_req low returns the node to error-active. halt_req has no effect in the other states.
- R7: A wr_en cycle with wr_data bit i = 1 clears flags[i] (bit 0 overload, bit 1 bus-off, bit 2 error-passive). A 0 bit leaves that flag unchanged, and a clear never changes node_state.
- R8: When a hardware set and a software clear hit the same flag in one cycle, the flag ends up set.
- R9: ovl_det sets flags[0] in every state and mode. ovl_tx_en is high for the one cycle after ovl_det only when listen_only is low and the node is error-active or error-passive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tec | input | CNT_W | Transmit error count |
| rec | input | CNT_W | Receive error count |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| ovl_det | input | 1 | Overload condition pulse |
| listen_only | input | 1 | Listen-only mode, blocks transmission |
| halt_req | input | 1 | Request to halt the node |
| force_passive | input | 1 | Test input forcing error-passive |
| wr_en | input | 1 | Flag clear write strobe |
| wr_data | input | 3 | Write-one-to-clear mask |
| node_state | output | 2 | Fault-confinement state |
| flags | output | 3 | Sticky interrupt flags |
| ovl_tx_en | output | 1 | Request to transmit an overload frame |

## Verification
A bench model runs alongside the design and is compared with it in every cycle. Directed sequences come first. Error-passive is reached through each of its three causes (rec, tec and the force input), which separates a per-transition flag from a level-following one. The recovery path is driven with a dominant bit in the middle of a run and with dominant levels on non-strobe cycles; this shows whether a dominant bit discards only the current run and whether unstrobed cycles are ignored. Colliding set and clear writes, zero-mask writes and overload pulses with listen-only on and off then separate set priority, write-one-to-clear and transmit gating. After that, constrained random counter levels, bus levels and halt requests with a fixed seed mix all the transitions, including halt arriving during recovery.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10,
    ST_HALTED  = 2'b11
  } node_st_t;

  localparam int NFLAG    = 3;
  localparam int FLG_OVL  = 0;
  localparam int FLG_BOFF = 1;
  localparam int FLG_PASS = 2;
endpackage

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int RUN_LEN   = 11,
  parameter int RUN_COUNT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic bit_stb,
  input  logic bus_rx,
  output logic done
);
  localparam int BW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam int RW = (RUN_COUNT > 1) ? $clog2(RUN_COUNT) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(RUN_LEN - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_COUNT - 1);

  logic [BW-1:0] bit_cnt;
  logic [RW-1:0] run_cnt;
  logic          run_end;

  assign run_end = en && bit_stb && bus_rx && (bit_cnt == BIT_LAST);
  assign done    = run_end && (run_cnt == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      bit_cnt <= '0;
      run_cnt <= '0;
    end else if (bit_stb) begin
      if (!bus_rx) begin
        bit_cnt <= '0;
      end else if (run_end) begin
        bit_cnt <= '0;
        run_cnt <= done ? '0 : run_cnt + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             force_passive,
  input  logic             halt_req,
  input  logic             rec_done,
  output node_st_t         state,
  output logic             ev_busoff,
  output logic             ev_passive
);
  localparam logic [CNT_W-1:0] EP_TH = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] BO_TH = CNT_W'(BUSOFF_LIM);

  node_st_t nxt;
  logic     passive_cond;
  logic     busoff_cond;

  assign busoff_cond  = (tec >= BO_TH);
  assign passive_cond = (tec >= EP_TH) || (rec >= EP_TH) || force_passive;

  always_comb begin
    nxt        = state;
    ev_busoff  = 1'b0;
    ev_passive = 1'b0;
    case (state)
      ST_ACTIVE: begin
        if (busoff_cond) begin
          nxt       = ST_BUSOFF;
          ev_busoff = 1'b1;
        end else if (passive_cond) begin
          nxt        = ST_PASSIVE;
          ev_passive = 1'b1;
        end
      end
      ST_PASSIVE: begin
        if (busoff_cond) begin
          nxt       = ST_BUSOFF;
          ev_busoff = 1'b1;
        end else if (!passive_cond) begin
          nxt = ST_ACTIVE;
        end
      end
      ST_BUSOFF: begin
        if (halt_req) begin
          nxt       = ST_HALTED;
          ev_busoff = 1'b1;
        end else if (rec_done) begin
          nxt       = ST_ACTIVE;
          ev_busoff = 1'b1;
        end
      end
      default: begin
        if (!halt_req) nxt = ST_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_ACTIVE;
    else     state <= nxt;
  end
endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      flags[i] <= 1'b0;
      else if (set_vec[i])          flags[i] <= 1'b1;
      else if (wr_en && wr_data[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/can_fault_irq.sv
module can_fault_irq
  import can_fc_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int RUN_LEN     = 11,
  parameter int RUN_COUNT   = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             bit_stb,
  input  logic             bus_rx,
  input  logic             ovl_det,
  input  logic             listen_only,
  input  logic             halt_req,
  input  logic             force_passive,
  input  logic             wr_en,
  input  logic [2:0]       wr_data,
  output logic [1:0]       node_state,
  output logic [2:0]       flags,
  output logic             ovl_tx_en
);
  node_st_t         st;
  logic             rec_done;
  logic             ev_busoff;
  logic             ev_passive;
  logic [NFLAG-1:0] set_vec;

  can_fc_recovery #(
    .RUN_LEN  (RUN_LEN),
    .RUN_COUNT(RUN_COUNT)
  ) u_recovery (
    .clk    (clk),
    .rst    (rst),
    .en     (st == ST_BUSOFF),
    .bit_stb(bit_stb),
    .bus_rx (bus_rx),
    .done   (rec_done)
  );

  can_fc_state #(
    .CNT_W      (CNT_W),
    .PASSIVE_LIM(PASSIVE_LIM),
    .BUSOFF_LIM (BUSOFF_LIM)
  ) u_state (
    .clk          (clk),
    .rst          (rst),
    .tec          (tec),
    .rec          (rec),
    .force_passive(force_passive),
    .halt_req     (halt_req),
    .rec_done     (rec_done),
    .state        (st),
    .ev_busoff    (ev_busoff),
    .ev_passive   (ev_passive)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLG_OVL]  = ovl_det;
    set_vec[FLG_BOFF] = ev_busoff;
    set_vec[FLG_PASS] = ev_passive;
  end

  can_fc_flags #(
    .N(NFLAG)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_vec),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .flags  (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) ovl_tx_en <= 1'b0;
    else     ovl_tx_en <= ovl_det && !listen_only &&
                          ((st == ST_ACTIVE) || (st == ST_PASSIVE));
  end

  assign node_state = st;
endmodule

// File: rtl/can_fault_irq_chk.sv
module can_fault_irq_chk #(
  parameter int CNT_W       = 9,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             force_passive,
  input logic             halt_req,
  input logic             ovl_det,
  input logic             listen_only,
  input logic             wr_en,
  input logic [2:0]       wr_data,
  input logic [1:0]       node_state,
  input logic [2:0]       flags,
  input logic             ovl_tx_en
);
  localparam logic [CNT_W-1:0] EP_TH = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] BO_TH = CNT_W'(BUSOFF_LIM);

  logic       running;
  logic [2:0] keep;
  assign running = (node_state == 2'b00) || (node_state == 2'b01);
  assign keep    = flags & ~(wr_en ? wr_data : 3'b000);

  // R2
  busoff_entry_chk: assert property (@(posedge clk) disable iff (rst)
    running && (tec >= BO_TH) |=> (node_state == 2'b10) && flags[1]);

  // R3
  passive_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (node_state == 2'b00) && (tec < BO_TH) &&
    ((tec >= EP_TH) || (rec >= EP_TH) || force_passive)
    |=> (node_state == 2'b01) && flags[2]);

  // R6
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (node_state == 2'b10) && halt_req |=> (node_state == 2'b11) && flags[1]);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (keep != 3'b000) |=> ((flags & $past(keep)) == $past(keep)));

  // R8
  ovl_set_chk: assert property (@(posedge clk) disable iff (rst)
    ovl_det |=> flags[0]);

  // R9
  listen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    listen_only |=> !ovl_tx_en);

  // R9
  ovl_tx_chk: assert property (@(posedge clk) disable iff (rst)
    ovl_det && !listen_only && running |=> ovl_tx_en);
endmodule

bind can_fault_irq can_fault_irq_chk #(
  .CNT_W      (CNT_W),
  .PASSIVE_LIM(PASSIVE_LIM),
  .BUSOFF_LIM (BUSOFF_LIM)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tec          (tec),
  .rec          (rec),
  .force_passive(force_passive),
  .halt_req     (halt_req),
  .ovl_det      (ovl_det),
  .listen_only  (listen_only),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .node_state   (node_state),
  .flags        (flags),
  .ovl_tx_en    (ovl_tx_en)
);

// File: tb/can_fault_irq_bench.sv
module can_fault_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] tec = '0;
  logic [8:0] rec = '0;
  logic       bit_stb = 1'b0;
  logic       bus_rx = 1'b1;
  logic       ovl_det = 1'b0;
  logic       listen_only = 1'b0;
  logic       halt_req = 1'b0;
  logic       force_passive = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = '0;
  logic [1:0] node_state;
  logic [2:0] flags;
  logic       ovl_tx_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_fault_irq u_can_fault_irq (
    .clk(clk), .rst(rst), .tec(tec), .rec(rec), .bit_stb(bit_stb),
    .bus_rx(bus_rx), .ovl_det(ovl_det), .listen_only(listen_only),
    .halt_req(halt_req), .force_passive(force_passive), .wr_en(wr_en),
    .wr_data(wr_data), .node_state(node_state), .flags(flags),
    .ovl_tx_en(ovl_tx_en)
  );

  // Reference model built from the requirements
  logic [1:0] m_st;
  logic [2:0] m_fl;
  logic       m_ovl;
  int         m_bits;
  int         m_runs;

  function automatic bit pass_cond(logic [8:0] t, logic [8:0] r, logic f);
    return (t >= 9'd128) || (r >= 9'd128) || f;
  endfunction

  always @(posedge clk) begin
    logic [1:0] ns;
    logic [2:0] setv;
    bit         rdone;
    if (rst) begin
      m_st = 2'b00; m_fl = 3'b000; m_ovl = 1'b0; m_bits = 0; m_runs = 0;
    end else begin
      ns = m_st; setv = {2'b00, ovl_det}; rdone = 1'b0;
      if (m_st == 2'b10 && bit_stb) begin
        if (!bus_rx) m_bits = 0;
        else if (m_bits == 10) begin
          m_bits = 0; m_runs++;
          if (m_runs == 128) begin rdone = 1'b1; m_runs = 0; end
        end else m_bits++;
      end
      case (m_st)
        2'b00: if (tec >= 9'd256) begin ns = 2'b10; setv[1] = 1'b1; end
               else if (pass_cond(tec, rec, force_passive)) begin ns = 2'b01; setv[2] = 1'b1; end
        2'b01: if (tec >= 9'd256) begin ns = 2'b10; setv[1] = 1'b1; end
               else if (!pass_cond(tec, rec, force_passive)) ns = 2'b00;
        2'b10: if (halt_req) begin ns = 2'b11; setv[1] = 1'b1; end
               else if (rdone) begin ns = 2'b00; setv[1] = 1'b1; end
        default: if (!halt_req) ns = 2'b00;
      endcase
      m_ovl = ovl_det && !listen_only && (m_st == 2'b00 || m_st == 2'b01);
      m_fl  = setv | (m_fl & ~(wr_en ? wr_data : 3'b000));
      if (ns != 2'b10) begin m_bits = 0; m_runs = 0; end
      m_st = ns;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " state"}, node_state, m_st);
    chk({tag, " flags"}, flags, m_fl);
    chk({tag, " ovl_tx_en"}, ovl_tx_en, m_ovl);
  endtask

  task automatic strobe_bits(int n, logic lvl, string tag);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1'b1; bus_rx = lvl; step(tag);
      bit_stb = 1'b0; bus_rx = 1'b0; step(tag);
    end
    bus_rx = 1'b1;
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = 3'b111; step("R7 clear");
    wr_en = 1'b0; wr_data = 3'b000;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 state", node_state, 0);
    chk("R1 flags", flags, 0);
    chk("R1 ovl_tx_en", ovl_tx_en, 0);

    // R3 via rec, flag only on the transition
    rec = 9'd130; step("R3");
    chk("R3 passive", node_state, 1);
    chk("R3 flag", flags, 3'b100);
    wr_en = 1'b1; wr_data = 3'b100; step("R7");
    wr_en = 1'b0; wr_data = 3'b000;
    step("R3"); step("R3");
    chk("R3 no reset", flags, 3'b000);
    chk("R7 state kept", node_state, 1);

    // R4 return
    rec = 9'd0; step("R4");
    chk("R4 active", node_state, 0);
    chk("R4 no flag", flags, 3'b000);

    // R3 via tec and via force
    tec = 9'd200; step("R3 tec");
    chk("R3 tec passive", node_state, 1);
    tec = 9'd0; step("R4"); clear_all();
    force_passive = 1'b1; step("R3 force");
    chk("R3 force passive", node_state, 1);
    chk("R3 force flag", flags[2], 1);
    force_passive = 1'b0; step("R4"); clear_all();

    // R9 overload, R7 zero mask, R8 collision
    ovl_det = 1'b1; step("R9");
    ovl_det = 1'b0;
    chk("R9 flag", flags[0], 1);
    chk("R9 tx", ovl_tx_en, 1);
    wr_en = 1'b1; wr_data = 3'b000; step("R7 zero");
    chk("R7 zero mask", flags[0], 1);
    chk("R9 tx one cycle", ovl_tx_en, 0);
    ovl_det = 1'b1; wr_data = 3'b001; step("R8");
    chk("R8 set wins", flags[0], 1);
    ovl_det = 1'b0; step("R7");
    chk("R7 cleared", flags[0], 0);
    wr_en = 1'b0; wr_data = 3'b000;
    listen_only = 1'b1; ovl_det = 1'b1; step("R9 listen");
    chk("R9 listen flag", flags[0], 1);
    chk("R9 listen no tx", ovl_tx_en, 0);
    ovl_det = 1'b0; listen_only = 1'b0; clear_all();

    // R2 bus-off entry
    tec = 9'd300; step("R2");
    chk("R2 busoff", node_state, 2);
    chk("R2 flag", flags[1], 1);
    tec = 9'd0; clear_all();
    halt_req = 1'b1; step("R6 halt"); halt_req = 1'b0;
    chk("R6 halted", node_state, 3);
    chk("R6 flag", flags[1], 1);
    step("R6 leave");
    chk("R6 active", node_state, 0);
    clear_all();

    // R5 recovery with a broken run
    tec = 9'd300; step("R2"); tec = 9'd0; clear_all();
    strobe_bits(64 * 11, 1'b1, "R5");
    strobe_bits(5, 1'b1, "R5");
    strobe_bits(1, 1'b0, "R5 dominant");
    strobe_bits(64 * 11 - 1, 1'b1, "R5");
    chk("R5 still busoff", node_state, 2);
    chk("R5 no flag yet", flags[1], 0);
    bit_stb = 1'b1; bus_rx = 1'b1; step("R5 last");
    bit_stb = 1'b0;
    chk("R5 recovered", node_state, 0);
    chk("R5 flag", flags[1], 1);
    clear_all();

    // Random phase covering all requirements
    for (int c = 0; c < 40000; c++) begin
      if (c % 40 == 0) begin
        int p = $urandom % 14;
        if (p < 10)      tec = 9'($urandom % 128);
        else if (p < 13) tec = 9'(128 + $urandom % 128);
        else             tec = 9'(256 + $urandom % 50);
        rec = ($urandom % 6 == 0) ? 9'(128 + $urandom % 100) : 9'($urandom % 128);
      end
      if (node_state == 2'b10 && c % 40 != 0) tec = 9'($urandom % 128);
      bit_stb       = ($urandom % 4) != 0;
      bus_rx        = ($urandom % 64) != 0;
      ovl_det       = ($urandom % 20) == 0;
      listen_only   = ($urandom % 3) == 0;
      force_passive = ($urandom % 50) == 0;
      if ($urandom % 700 == 0) halt_req = ~halt_req;
      wr_en         = ($urandom % 8) == 0;
      wr_data       = 3'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule